// File: doc/BRIEF.md
# Programmable Edge-Delay Pulse Qualifier

This block passes a single digital input through to its output only once the input has settled at a new level for a programmed number of master ticks. A transition that reverts before the count finishes is discarded, so the block can serve as a switch debouncer or as a noise discriminator on a slow control line. The time base is a one-cycle enable, `tick`, that comes from the system clock domain. The delay is a power of eight in tick periods, from 1 up to 2^21.

A 4-bit configuration word sets both the delay exponent and one policy bit. The static parameter `DUAL_EDGE` decides what that bit means. With `DUAL_EDGE` = 0, only one transition direction is qualified and the opposite direction passes straight through. With `DUAL_EDGE` = 1, both directions are qualified and the policy bit inverts the output.

Top module: `edge_delay_qualifier`

## Requirements
- R1: While `rst_n` is low, the qualified level is 0. `dout` then reads 1 when `DUAL_EDGE`=1 and `cfg[3]`=1, and 0 in every other case.
- R2: After reset is released, the qualified level takes the steady `din` level without any delay, so `dout` matches `din` (after any inversion) within 8 clocks.
- R3: `cfg[2:0]` holds an exponent k. The delay factor is F = 8^k ticks: 1, 8, 64, 512 and so on up to 2^21.
- R4: `din` passes through a two-flop synchronizer. If `din` changes just after clock edge P and stays put, a qualified transition appears at `dout` right after edge P+2+F when `tick` is high on every clock.
- R5: The count advances only on clocks where `tick` is 1. A qualified transition lands on the clock that carries the F-th tick at or after edge P+3.
- R6: If the synchronized input returns to the current qualified level before F ticks have been counted, `dout` does not change and the count restarts from zero. A pulse that lasts exactly F cycles (with `tick` always high) does pass.
- R7: With `DUAL_EDGE`=0, `cfg[3]`=0 qualifies rising transitions and `cfg[3]`=1 qualifies falling ones. A transition in the other direction reaches `dout` right after edge P+3, whatever F is.
- R8: With `DUAL_EDGE`=1, both directions are qualified, and `cfg[3]`=1 inverts `dout`. The inversion is combinational from `cfg`, so it takes effect in the same cycle.
- R9: Any change of `cfg` while a count is pending throws away the partial count. Counting then restarts from zero under the new factor, starting on the next clock.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| tick | input | 1 | Master tick enable that advances the delay count |
| din | input | 1 | Asynchronous input to be qualified |
| cfg | input | 4 | Bits [2:0]: delay exponent; bit [3]: edge choice or inversion |
| dout | output | 1 | Qualified output |

## Verification
The bench aims at the one-cycle edges of the delay window. A pulse one cycle shorter than F must vanish and a pulse exactly F long must pass, so an off-by-one in the terminal compare flips one of the two results. It changes the code in the middle of a count: a design that keeps the stale count moves the output three cycles early. It also checks the reset-time level directly, because a design without priming would make the first output wait a full delay. Finally it runs a half-rate tick and the direct pass of the undelayed edge, which catch counting on every clock and a delay applied to the wrong direction.

// File: rtl/eq_pkg.sv
package eq_pkg;
  // Per-direction qualification policy derived from the configuration word.
  typedef struct packed {
    logic hold_rise;   // rising transitions wait for the full count
    logic hold_fall;   // falling transitions wait for the full count
    logic invert;      // output polarity flip
  } eq_policy_t;
endpackage

// File: rtl/eq_sync.sv
module eq_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  generate
    if (STAGES == 1) begin : g_single
      always_comb chain_d = d;
    end else begin : g_multi
      always_comb chain_d = {chain_q[STAGES-2:0], d};
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign q = chain_q[STAGES-1];
endmodule

// File: rtl/eq_policy.sv
module eq_policy
  import eq_pkg::*;
#(
  parameter bit DUAL_EDGE  = 1'b1,
  parameter int EXP_W      = 3,
  parameter int STEP_SHIFT = 3,
  parameter int CNT_W      = 22,
  localparam int CFG_W     = EXP_W + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CFG_W-1:0] cfg,
  output logic [CNT_W-1:0] term,
  output eq_policy_t       policy,
  output logic             cfg_chg
);
  logic [CFG_W-1:0] cfg_q;
  logic             sel_bit;

  assign sel_bit = cfg[CFG_W-1];

  // Factor 2^(STEP_SHIFT*k): one-hot terminal count.
  always_comb term = CNT_W'(1) << (STEP_SHIFT * int'(cfg[EXP_W-1:0]));

  generate
    if (DUAL_EDGE) begin : g_dual
      always_comb begin
        policy.hold_rise = 1'b1;
        policy.hold_fall = 1'b1;
        policy.invert    = sel_bit;
      end
    end else begin : g_single
      always_comb begin
        policy.hold_rise = ~sel_bit;
        policy.hold_fall = sel_bit;
        policy.invert    = 1'b0;
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cfg_q <= '0;
    else        cfg_q <= cfg;
  end

  assign cfg_chg = (cfg != cfg_q);
endmodule

// File: rtl/eq_delay_core.sv
module eq_delay_core
  import eq_pkg::*;
#(
  parameter int CNT_W = 22
) (
  input  logic             clk,
  input  logic             rst_ni,
  input  logic             tick,
  input  logic             s,
  input  logic [CNT_W-1:0] term,
  input  eq_policy_t       policy,
  input  logic             cfg_chg,
  output logic             lvl
);
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [1:0]       prime_q, prime_d;
  logic             lvl_d;
  logic             primed, differ, rising, held;

  assign primed = (prime_q == 2'd3);
  assign differ = s ^ lvl;
  assign rising = s & ~lvl;
  assign held   = differ & (rising ? policy.hold_rise : policy.hold_fall);

  always_comb begin
    lvl_d   = lvl;
    cnt_d   = cnt_q;
    prime_d = prime_q;
    if (!primed) begin
      lvl_d   = s;
      cnt_d   = '0;
      prime_d = prime_q + 2'd1;
    end else if (!differ) begin
      cnt_d = '0;
    end else if (!held) begin
      lvl_d = s;
      cnt_d = '0;
    end else if (cfg_chg) begin
      cnt_d = '0;
    end else if (tick) begin
      if (cnt_q == term - CNT_W'(1)) begin
        lvl_d = s;
        cnt_d = '0;
      end else begin
        cnt_d = cnt_q + CNT_W'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      lvl     <= 1'b0;
      cnt_q   <= '0;
      prime_q <= 2'd0;
    end else begin
      lvl     <= lvl_d;
      cnt_q   <= cnt_d;
      prime_q <= prime_d;
    end
  end

  // R4: the qualified level only ever moves to the synchronized input value
  a_r4_moves_to_input: assert property (@(posedge clk) disable iff (!rst_ni)
    !$stable(lvl) |-> (lvl == $past(s)));

  // R5: a held transition never lands on a clock without a tick
  a_r5_no_tick_no_move: assert property (@(posedge clk) disable iff (!rst_ni)
    (primed && held && !tick) |=> $stable(lvl));

  // R6: a count never exceeds the factor while the code is steady
  a_r6_count_bounded: assert property (@(posedge clk) disable iff (!rst_ni)
    (primed && !cfg_chg) |-> (cnt_q < term));

  // R6: agreement between input and level clears the count
  a_r6_clear_on_match: assert property (@(posedge clk) disable iff (!rst_ni)
    (s == lvl) |=> (cnt_q == '0));

  // R9: a code change discards the partial count
  a_r9_abort_on_cfg: assert property (@(posedge clk) disable iff (!rst_ni)
    cfg_chg |=> (cnt_q == '0));
endmodule

// File: rtl/edge_delay_qualifier.sv
module edge_delay_qualifier
  import eq_pkg::*;
#(
  parameter bit DUAL_EDGE   = 1'b1,
  parameter int EXP_W       = 3,
  parameter int STEP_SHIFT  = 3,
  parameter int SYNC_STAGES = 2,
  localparam int CFG_W      = EXP_W + 1,
  localparam int MAX_EXP    = (1 << EXP_W) - 1,
  localparam int CNT_W      = STEP_SHIFT * MAX_EXP + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             din,
  input  logic [CFG_W-1:0] cfg,
  output logic             dout
);
  logic             rst_ni;
  logic             s;
  logic [CNT_W-1:0] term;
  eq_policy_t       policy;
  logic             cfg_chg;
  logic             lvl;

  // Reset: asynchronous assertion, synchronous release.
  eq_sync #(.STAGES(2)) u_rst_sync (
    .clk(clk), .rst_n(rst_n), .d(1'b1), .q(rst_ni)
  );

  eq_sync #(.STAGES(SYNC_STAGES)) u_din_sync (
    .clk(clk), .rst_n(rst_ni), .d(din), .q(s)
  );

  eq_policy #(
    .DUAL_EDGE(DUAL_EDGE), .EXP_W(EXP_W), .STEP_SHIFT(STEP_SHIFT), .CNT_W(CNT_W)
  ) u_policy (
    .clk(clk), .rst_n(rst_ni), .cfg(cfg),
    .term(term), .policy(policy), .cfg_chg(cfg_chg)
  );

  eq_delay_core #(.CNT_W(CNT_W)) u_core (
    .clk(clk), .rst_ni(rst_ni), .tick(tick), .s(s),
    .term(term), .policy(policy), .cfg_chg(cfg_chg), .lvl(lvl)
  );

  assign dout = lvl ^ policy.invert;

  // R8: single-edge builds never invert the output
  a_r8_no_invert_single: assert property (@(posedge clk) disable iff (!rst_ni)
    !DUAL_EDGE |-> (dout == lvl));
endmodule

// File: tb/edge_delay_qualifier_test.sv
module edge_delay_qualifier_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick = 1'b1;
  logic       din = 1'b0;
  logic [3:0] cfg = 4'd0;
  logic       dout, dout_se;
  logic       tick_alt = 1'b0;
  int         cyc = 0;
  int         compared = 0;
  int         mismatched = 0;
  bit         done = 1'b0;

  typedef struct {
    int    at;
    bit    se;
    bit    val;
    string req;
  } exp_t;
  exp_t q[$];

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  edge_delay_qualifier #(.DUAL_EDGE(1'b1)) uut (
    .clk(clk), .rst_n(rst_n), .tick(tick), .din(din), .cfg(cfg), .dout(dout)
  );
  edge_delay_qualifier #(.DUAL_EDGE(1'b0)) uut_se (
    .clk(clk), .rst_n(rst_n), .tick(tick), .din(din), .cfg(cfg), .dout(dout_se)
  );

  task automatic expect_at(input int at, input bit se, input bit val, input string req);
    exp_t e;
    e.at = at; e.se = se; e.val = val; e.req = req;
    q.push_back(e);
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic int alt_edge(input int p, input int f);
    int n = 0;
    for (int e = p + 3; e < p + 10000; e++) begin
      if (e % 2 == 0) begin
        n++;
        if (n == f) return e;
      end
    end
    return -1;
  endfunction

  // Tick driver
  initial begin
    forever begin
      @(negedge clk);
      tick = tick_alt ? (((cyc + 1) % 2) == 0) : 1'b1;
    end
  end

  // Monitor: compare scoreboard items in their cycle
  initial begin
    forever begin
      @(negedge clk);
      #1;
      for (int i = q.size() - 1; i >= 0; i--) begin
        if (q[i].at == cyc) begin
          logic got;
          got = q[i].se ? dout_se : dout;
          compared++;
          if (got !== q[i].val) begin
            mismatched++;
            $display("FAIL %s cyc=%0d %s actual=%b expected=%b", q[i].req, cyc,
                     q[i].se ? "single" : "dual", got, q[i].val);
          end
          q.delete(i);
        end
      end
    end
  end

  // Watchdog
  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      mismatched++;
      $display("FAIL watchdog (all requirements) actual=hung expected=done");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    int p, p2, e;
    // R1: reset state, inversion selected in dual build only
    cfg = 4'b1000; din = 1'b1;
    step(2);
    expect_at(cyc + 1, 1'b0, 1'b1, "R1");
    expect_at(cyc + 1, 1'b1, 1'b0, "R1");
    step(3);
    // R2: reset-time level taken without delay (F=8 would otherwise hold it)
    cfg = 4'b0001;
    step(1);
    rst_n = 1'b1;
    p = cyc;
    expect_at(p + 8, 1'b0, 1'b1, "R2");
    expect_at(p + 8, 1'b1, 1'b1, "R2");
    step(12);

    // R4 / R3: falling edge, F=8, dual delays; R7: single passes falling
    p = cyc; din = 1'b0;
    expect_at(p + 9, 1'b0, 1'b1, "R4");
    expect_at(p + 10, 1'b0, 1'b0, "R4");
    expect_at(p + 2, 1'b1, 1'b1, "R7");
    expect_at(p + 3, 1'b1, 1'b0, "R7");
    step(15);

    // R8 / R7: rising edge delayed in both builds
    p = cyc; din = 1'b1;
    expect_at(p + 9, 1'b0, 1'b0, "R8");
    expect_at(p + 10, 1'b0, 1'b1, "R8");
    expect_at(p + 9, 1'b1, 1'b0, "R7");
    expect_at(p + 10, 1'b1, 1'b1, "R7");
    step(15);

    // R6: pulse of F-1 cycles is discarded
    p = cyc; din = 1'b0;
    step(7); din = 1'b1;
    expect_at(p + 10, 1'b0, 1'b1, "R6");
    expect_at(p + 14, 1'b0, 1'b1, "R6");
    step(30);

    // R6: pulse of exactly F cycles passes
    p = cyc; din = 1'b0;
    expect_at(p + 9, 1'b0, 1'b1, "R6");
    expect_at(p + 10, 1'b0, 1'b0, "R6");
    step(8); din = 1'b1;
    step(30);
    expect_at(cyc, 1'b0, 1'b1, "R6");

    // R3: F=64 on a falling edge
    cfg = 4'b0010;
    step(3);
    p = cyc; din = 1'b0;
    expect_at(p + 65, 1'b0, 1'b1, "R3");
    expect_at(p + 66, 1'b0, 1'b0, "R3");
    step(80);

    // R5: half-rate tick, F=8, rising edge
    cfg = 4'b0001; tick_alt = 1'b1;
    step(3);
    p = cyc; din = 1'b1;
    e = alt_edge(p, 8);
    expect_at(e - 1, 1'b0, 1'b0, "R5");
    expect_at(e, 1'b0, 1'b1, "R5");
    expect_at(e - 1, 1'b1, 1'b0, "R5");
    expect_at(e, 1'b1, 1'b1, "R5");
    step(40);
    tick_alt = 1'b0;
    step(3);

    // R8: inversion applies in the same cycle; R7: single now holds falling
    cfg = 4'b1001;
    expect_at(cyc, 1'b0, 1'b0, "R8");
    expect_at(cyc, 1'b1, 1'b1, "R7");
    step(3);
    p = cyc; din = 1'b0;
    expect_at(p + 9, 1'b1, 1'b1, "R7");
    expect_at(p + 10, 1'b1, 1'b0, "R7");
    expect_at(p + 9, 1'b0, 1'b0, "R8");
    expect_at(p + 10, 1'b0, 1'b1, "R8");
    step(20);
    p2 = cyc; din = 1'b1;
    expect_at(p2 + 2, 1'b1, 1'b0, "R7");
    expect_at(p2 + 3, 1'b1, 1'b1, "R7");
    expect_at(p2 + 9, 1'b0, 1'b1, "R8");
    expect_at(p2 + 10, 1'b0, 1'b0, "R8");
    step(20);

    // R9: code change mid-count restarts under the new factor
    cfg = 4'b0010;
    step(3);
    p = cyc; din = 1'b0;
    step(4); cfg = 4'b0001;
    expect_at(p + 12, 1'b0, 1'b1, "R9");
    expect_at(p + 13, 1'b0, 1'b0, "R9");
    step(25);

    // R3: F=512 rising edge in both builds
    cfg = 4'b0011;
    step(3);
    p = cyc; din = 1'b1;
    expect_at(p + 513, 1'b0, 1'b0, "R3");
    expect_at(p + 514, 1'b0, 1'b1, "R3");
    expect_at(p + 514, 1'b1, 1'b1, "R3");
    step(520);

    foreach (q[i]) begin
      mismatched++;
      $display("FAIL %s never compared actual=none expected=%b", q[i].req, q[i].val);
    end
    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule